// File: doc/BRIEF.md
# PS/2 Device-Side Bidirectional Transceiver

This block is the device end (keyboard or mouse end) of a two-wire serial link. Both wires are open-drain. The device generates the bus clock. On a user request the block frames a byte for the host as one start bit, eight data bits sent least significant bit first, an odd parity bit and a stop bit. It drives the bus clock through a fixed sequence of steps, and it advances one step on each tick of a timebase that runs at half the bus clock period.

While idle, the block releases both wires and looks at them on a slower poll tick. If the clock is released and data is low, the host is requesting to send. The block then clocks in a host byte, checks its parity, returns the acknowledge pulse and delivers the byte with a one-cycle valid strobe. If the host holds the clock low while the block is sending, the block abandons the send and turns the transfer into a receive.

Each wire has a pull-low enable output and a raw input. Both inputs pass through a synchronizer before the block samples them. Line filtering and scan-code translation are left to other blocks.

Top module: `ps2_dev_xcvr`

## Requirements
- R1: After a synchronous reset, both pull enables are 0 and `rx_valid` is 0. Once both lines read high through the synchronizer, `ready` is 1.
- R2: The block only ever pulls a line low or releases it. A data value of 1 is sent by releasing the line (`dat_pull_o`=0), and a 0 by pulling it (`dat_pull_o`=1).
- R3: `ready` is 1 only when the block is idle and both synchronized lines are high. A `snd_req` pulse made while `ready` is 0 is ignored, and neither line is pulled as a result.
- R4: A send makes exactly 11 bus clock falling edges, where a falling edge is `clk_pull_o` going 0 to 1. The data line at those edges carries, in order: start 0, data bits 0 to 7, parity, stop 1. The parity bit makes the count of ones in data plus parity odd.
- R5: An accepted send consumes exactly 26 `half_tick` pulses. `ready` stays 0 from the request until the block returns to idle, and the step advances only on `half_tick`.
- R6: During a send, the block samples the released clock on each step where it is about to pull the clock low (steps 4 to 18). If the clock reads low, the block releases data, pulls the clock and continues as a receive. With the host data released, that receive delivers 0xFF with no parity error.
- R7: While idle, a released clock together with a low data line seen on a `poll_tick` starts a receive. A low clock with high data does not start one.
- R8: A received frame's data bits, sampled least significant bit first, appear on `rx_byte` with a single-cycle `rx_valid` pulse.
- R9: After the host's parity bit, the block pulls data low while it releases the clock (the acknowledge), then releases both lines.
- R10: `rx_par_err` is 1 with `rx_valid` when the eight data bits and the received parity bit hold an even count of ones, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| half_tick | input | 1 | One-cycle pulse every half bus-clock period |
| poll_tick | input | 1 | One-cycle pulse at the idle poll rate |
| clk_line_i | input | 1 | Raw bus clock line level |
| dat_line_i | input | 1 | Raw bus data line level |
| clk_pull_o | output | 1 | 1 pulls the bus clock low, 0 releases it |
| dat_pull_o | output | 1 | 1 pulls the bus data low, 0 releases it |
| snd_req | input | 1 | One-cycle request to send `snd_byte` |
| snd_byte | input | DATA_W | Byte to send to the host |
| ready | output | 1 | Idle with both lines high, so a send is accepted |
| rx_byte | output | DATA_W | Last byte received from the host |
| rx_valid | output | 1 | One-cycle strobe when `rx_byte` is updated |
| rx_par_err | output | 1 | Parity error on the delivered byte |

## Verification
The bench builds the block with DATA_W=8 and SYNC_STAGES=2. It spaces `half_tick` 8 cycles apart and `poll_tick` 32 cycles apart. That spacing leaves room for the synchronizer delay, so a host model wired-AND onto both lines can change data between device clock edges. It can also hold the clock low at a chosen falling edge to force the abort into receive. Random bytes in both directions, with occasional corrupted parity, reach every data bit value and both parity outcomes. A directed inhibit case covers the refused request.

// File: rtl/ps2_dev_xcvr.sv
module ps2_dev_xcvr #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_tick,
  input  logic              poll_tick,
  input  logic              clk_line_i,
  input  logic              dat_line_i,
  output logic              clk_pull_o,
  output logic              dat_pull_o,
  input  logic              snd_req,
  input  logic [DATA_W-1:0] snd_byte,
  output logic              ready,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              rx_par_err
);

  localparam int STEP_W = $clog2(2*DATA_W + 11);
  localparam logic [STEP_W-1:0] S1       = STEP_W'(1);
  localparam logic [STEP_W-1:0] S2       = STEP_W'(2);
  localparam logic [STEP_W-1:0] S3       = STEP_W'(3);
  localparam logic [STEP_W-1:0] S4       = STEP_W'(4);
  localparam logic [STEP_W-1:0] ODD_LAST = STEP_W'(2*DATA_W + 1);
  localparam logic [STEP_W-1:0] EVN_LAST = STEP_W'(2*DATA_W + 2);
  localparam logic [STEP_W-1:0] PAR      = STEP_W'(2*DATA_W + 3);
  localparam logic [STEP_W-1:0] SND_END  = STEP_W'(2*DATA_W + 10);

  typedef enum logic [1:0] {IDLE, SEND, RECV} mode_t;

  mode_t                  state;
  logic [STEP_W-1:0]      step;
  logic [SYNC_STAGES-1:0] csync, dsync;
  logic [DATA_W-1:0]      tx_sh, rx_sh;
  logic                   par_acc, rx_par;
  logic                   clk_s, dat_s, odd_data, even_data;

  assign clk_s     = csync[SYNC_STAGES-1];
  assign dat_s     = dsync[SYNC_STAGES-1];
  assign ready     = (state == IDLE) && clk_s && dat_s;
  assign odd_data  = (step >= S3) && (step <= ODD_LAST) && step[0];
  assign even_data = (step >= S4) && (step <= EVN_LAST) && !step[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      csync <= '1;
      dsync <= '1;
    end else begin
      csync <= {csync[SYNC_STAGES-2:0], clk_line_i};
      dsync <= {dsync[SYNC_STAGES-2:0], dat_line_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= IDLE;
      step       <= '0;
      clk_pull_o <= 1'b0;
      dat_pull_o <= 1'b0;
      tx_sh      <= '0;
      rx_sh      <= '0;
      par_acc    <= 1'b0;
      rx_par     <= 1'b0;
      rx_byte    <= '0;
      rx_valid   <= 1'b0;
      rx_par_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        IDLE: begin
          clk_pull_o <= 1'b0;
          dat_pull_o <= 1'b0;
          step       <= '0;
          if (snd_req && ready) begin
            state   <= SEND;
            step    <= S1;
            tx_sh   <= snd_byte;
            par_acc <= 1'b0;
          end else if (poll_tick && clk_s && !dat_s) begin
            state <= RECV;
            step  <= S1;
          end
        end
        SEND: if (half_tick) begin
          step <= step + S1;
          if (step == S1) dat_pull_o <= 1'b1;
          else if (step == S2) clk_pull_o <= 1'b1;
          else if (odd_data) begin
            dat_pull_o <= ~tx_sh[0];
            par_acc    <= par_acc ^ tx_sh[0];
            tx_sh      <= tx_sh >> 1;
            clk_pull_o <= 1'b0;
          end else if (even_data) begin
            clk_pull_o <= 1'b1;
            if (!clk_s) begin
              state      <= RECV;
              step       <= S2;
              dat_pull_o <= 1'b0;
            end
          end else if (step == PAR) begin
            dat_pull_o <= par_acc;
            clk_pull_o <= 1'b0;
          end else if (step == PAR + S1) clk_pull_o <= 1'b1;
          else if (step == PAR + S2) begin
            clk_pull_o <= 1'b0;
            dat_pull_o <= 1'b0;
          end else if (step == PAR + S3) clk_pull_o <= 1'b1;
          else if (step == PAR + S4) clk_pull_o <= 1'b0;
          else if (step >= SND_END) begin
            state <= IDLE;
            step  <= '0;
          end
        end
        RECV: if (half_tick) begin
          step <= step + S1;
          if (step == S1) begin
            clk_pull_o <= 1'b1;
            rx_sh      <= '0;
          end else if (step == S2) clk_pull_o <= 1'b0;
          else if (odd_data) begin
            clk_pull_o <= 1'b1;
            rx_sh      <= {dat_s, rx_sh[DATA_W-1:1]};
          end else if (even_data) clk_pull_o <= 1'b0;
          else if (step == PAR) begin
            clk_pull_o <= 1'b1;
            rx_par     <= dat_s;
          end else if (step == PAR + S1) begin
            clk_pull_o <= 1'b0;
            dat_pull_o <= 1'b1;
          end else if (step == PAR + S2) clk_pull_o <= 1'b1;
          else if (step == PAR + S3) begin
            clk_pull_o <= 1'b0;
            dat_pull_o <= 1'b0;
          end else begin
            rx_byte    <= rx_sh;
            rx_valid   <= 1'b1;
            rx_par_err <= ~(^rx_sh ^ rx_par);
            state      <= IDLE;
            step       <= '0;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == IDLE) |-> (!clk_pull_o && !dat_pull_o)); // R2
  AST_REFUSED_REQ: assert property (@(posedge clk) disable iff (rst)
    (state == IDLE && snd_req && !ready) |=> (state != SEND)); // R3
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state != IDLE && !half_tick) |=> $stable(step)); // R5
  AST_ABORT_TO_RX: assert property (@(posedge clk) disable iff (rst)
    (state == SEND && half_tick && even_data && !clk_s) |=>
      (state == RECV && clk_pull_o && !dat_pull_o)); // R6
  AST_RXV_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R8
  AST_ACK_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (state == RECV && dat_pull_o) |-> (step == PAR + S2 || step == PAR + S3)); // R9

endmodule

// File: tb/tb_ps2_dev_xcvr.sv
module tb_ps2_dev_xcvr;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 8;

  logic clk = 0, rst = 1, half_tick = 0, poll_tick = 0;
  logic host_clk_low = 0, host_dat_low = 0;
  logic snd_req = 0;
  logic [DATA_W-1:0] snd_byte = '0;
  logic clk_pull_o, dat_pull_o, ready, rx_valid, rx_par_err;
  logic [DATA_W-1:0] rx_byte;
  logic clk_line, dat_line;
  int n_tests = 0, n_fail = 0;

  assign clk_line = ~(clk_pull_o | host_clk_low);
  assign dat_line = ~(dat_pull_o | host_dat_low);

  ps2_dev_xcvr #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .half_tick(half_tick), .poll_tick(poll_tick),
    .clk_line_i(clk_line), .dat_line_i(dat_line),
    .clk_pull_o(clk_pull_o), .dat_pull_o(dat_pull_o),
    .snd_req(snd_req), .snd_byte(snd_byte), .ready(ready),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_par_err(rx_par_err));

  always #(CLK_P/2) clk = ~clk;

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      half_tick = (cnt % 8) == 0;
      poll_tick = (cnt % 32) == 5;
    end
  end

  function automatic logic odd_par(input logic [DATA_W-1:0] b);
    return ~^b;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P*190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  task automatic wait_ready();
    int guard = 0;
    while (!ready && guard < 2000) begin @(negedge clk); guard++; end
  endtask

  task automatic dev_send(input logic [DATA_W-1:0] b);
    logic [10:0] bits = '0;
    int falls = 0, ticks = 0, guard = 0;
    logic prev;
    logic [10:0] expb;
    wait_ready();
    @(negedge clk);
    check("R3 ready before send", ready, 1);
    snd_req = 1; snd_byte = b;
    @(negedge clk);
    snd_req = 0;
    prev = clk_pull_o;
    while (!ready && guard < 2000) begin
      if (half_tick) ticks++;
      if (clk_pull_o && !prev) begin
        if (falls < 11) bits[falls] = dat_line;
        falls++;
      end
      prev = clk_pull_o;
      @(negedge clk);
      guard++;
    end
    expb = {1'b1, odd_par(b), b, 1'b0};
    check("R4 falling edges", falls, 11);
    check("R4 frame bits", bits, expb);
    check("R5 tick count", ticks, 26);
  endtask

  task automatic wait_rise();
    int g = 0;
    while (!clk_pull_o && g < 2000) begin @(negedge clk); g++; end
    while (clk_pull_o && g < 4000) begin @(negedge clk); g++; end
  endtask

  task automatic wait_fall();
    int g = 0;
    while (clk_pull_o && g < 2000) begin @(negedge clk); g++; end
    while (!clk_pull_o && g < 4000) begin @(negedge clk); g++; end
  endtask

  task automatic wait_rxv(output logic got);
    int g = 0;
    got = 0;
    while (!rx_valid && g < 3000) begin @(negedge clk); g++; end
    got = rx_valid;
  endtask

  task automatic host_send(input logic [DATA_W-1:0] b, input logic bad);
    logic par, got;
    wait_ready();
    @(negedge clk);
    par = odd_par(b) ^ bad;
    host_dat_low = 1;
    for (int i = 0; i <= DATA_W; i++) begin
      wait_rise();
      host_dat_low = (i < DATA_W) ? ~b[i] : ~par;
    end
    wait_fall();
    host_dat_low = 0;
    wait_rise();
    check("R9 ack pull", {clk_pull_o, dat_pull_o}, 2'b01);
    wait_rxv(got);
    check("R8 rx_valid", got, 1);
    check("R8 rx_byte", rx_byte, b);
    check("R10 parity flag", rx_par_err, bad);
    @(negedge clk);
    check("R8 strobe single", rx_valid, 0);
  endtask

  initial begin
    int falls;
    logic prev, got, seen;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 pulls after reset", {clk_pull_o, dat_pull_o}, 2'b00);
    check("R1 rx_valid after reset", rx_valid, 0);
    repeat (3) @(negedge clk);
    check("R1 ready after reset", ready, 1);

    dev_send(8'h00);
    dev_send(8'hFF);
    dev_send(8'hA5);
    dev_send(8'h01);
    for (int k = 0; k < 16; k++) dev_send(DATA_W'($urandom));

    // R7: RTS starts a receive; R2 ack pulls only
    host_send(8'h5A, 0);
    host_send(8'h80, 0);
    host_send(8'h3C, 1);
    for (int k = 0; k < 16; k++) host_send(DATA_W'($urandom), ($urandom % 4) == 0);

    // R3: inhibit, refused request, no line activity; R7 low clock high data no receive
    wait_ready();
    host_clk_low = 1;
    repeat (4) @(negedge clk);
    check("R3 ready low when inhibited", ready, 0);
    snd_req = 1; snd_byte = 8'h77;
    @(negedge clk);
    snd_req = 0;
    seen = 0;
    for (int c = 0; c < 300; c++) begin
      if (clk_pull_o || dat_pull_o || rx_valid) seen = 1;
      @(negedge clk);
    end
    check("R3 refused request no activity", seen, 0);
    check("R7 inhibit not a request", seen, 0);
    host_clk_low = 0;
    repeat (4) @(negedge clk);
    check("R3 ready after release", ready, 1);

    // R6: host holds clock low mid send
    snd_req = 1; snd_byte = 8'h12;
    @(negedge clk);
    snd_req = 0;
    falls = 0; prev = clk_pull_o;
    while (falls < 3) begin
      @(negedge clk);
      if (clk_pull_o && !prev) falls++;
      prev = clk_pull_o;
    end
    host_clk_low = 1;
    repeat (40) @(negedge clk);
    check("R6 data released after abort", dat_pull_o, 0);
    host_clk_low = 0;
    wait_rxv(got);
    check("R6 receive after abort", got, 1);
    check("R6 abort byte", rx_byte, 8'hFF);
    check("R6 abort parity", rx_par_err, 0);
    wait_ready();
    dev_send(8'hC3);
    finish_up();
  end
endmodule